// File: doc/BRIEF.md
# Shared FIFO and Palette RAM

This block gives each processing core a 128-word by 32-bit storage array with two ports. The core-side port and the I/O/video-side port each have an enable, a write strobe, an address and data. A small configuration register picks how the array behaves. There are three modes.

- **RAM mode.** Both ports read and write freely.
- **FIFO mode.** The storage becomes a queue between the core and a timed I/O engine. A direction bit makes one port the only writer and the other the only reader. Internal 7-bit read and write counters replace the addresses.
- **Palette mode.** The video side sends pixel indices of 1, 2, 4 or 8 bits. Each index selects one of two 16-bit colour entries packed into every word, and the colour comes out split into red, green, blue and a sync bit.

Every read is registered and appears one cycle after the request. Both ports run on a single clock. Writing the configuration register resets the queue counters and the overflow flag.

Top module: `fifo_clut_ram`

## Requirements
- R1: After reset, both read-data outputs and the colour outputs are zero, `fifo_empty` is 1, `fifo_full` and `fifo_ovf` are 0, and the mode is RAM.
- R2: RAM mode (`cfg_mode` 0 or 3). A read on either port (`en`=1, `we`=0) shows the addressed word on that port's read data one cycle later. A read of an address that is being written in the same cycle returns the old word.
- R3: RAM mode. If both ports write in the same cycle, the core write is kept and the I/O write is dropped.
- R4: FIFO mode (`cfg_mode`=1). Words pushed by the writer come out at the reader in push order. A pop (`en`=1, `we`=0 on the reader port) shows the head word one cycle later.
- R5: `fifo_empty` is 1 exactly when the read and write counters are equal. `fifo_full` is 1 when 127 words are held.
- R6: A push while full is dropped and sets `fifo_ovf`. The flag stays set until the next configuration write. A pop in the same cycle does not make room for that push.
- R7: A pop while empty is ignored. The reader's read data keeps its value and the counters do not move.
- R8: In FIFO mode, a write strobe on the reader port writes nothing.
- R9: A configuration write (`cfg_wr`=1) loads the mode, direction and depth, and empties the FIFO. `fifo_ovf` is cleared.
- R10: `cfg_dir`=0 makes the core port the writer and the I/O port the reader. `cfg_dir`=1 swaps the two roles.
- R11: Palette mode (`cfg_mode`=2). A lookup (`io_en`=1, `io_we`=0) first masks `pix_idx` to its low 1, 2, 4 or 8 bits, for `cfg_bpp` 0, 1, 2 or 3. The masked index shifted right by one is the word address. Masked bit 0 picks the low (0) or high (1) 16-bit half.
- R12: The selected 16-bit entry is laid out as bit 15 sync, bits 14:10 red, bits 9:5 green and bits 4:0 blue. These fields drive `pix_hsync`, `pix_red`, `pix_green` and `pix_blue` one cycle after the lookup.
- R13: In palette mode, writes from the I/O port are ignored. The core port still reads and writes at its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Load the configuration register |
| cfg_mode | input | 2 | 0 RAM, 1 FIFO, 2 palette, 3 RAM |
| cfg_dir | input | 1 | FIFO writer: 0 core, 1 I/O |
| cfg_bpp | input | 2 | Pixel depth code: 1, 2, 4 or 8 bits |
| c_en | input | 1 | Core port request |
| c_we | input | 1 | Core port write strobe |
| c_addr | input | 7 | Core port word address |
| c_wdata | input | 32 | Core port write data |
| c_rdata | output | 32 | Core port read data |
| io_en | input | 1 | I/O port request |
| io_we | input | 1 | I/O port write strobe |
| io_addr | input | 7 | I/O port word address |
| io_wdata | input | 32 | I/O port write data |
| io_rdata | output | 32 | I/O port read data (whole word in palette mode) |
| pix_idx | input | 8 | Pixel index for palette lookups |
| pix_red | output | 5 | Red field of the looked-up entry |
| pix_green | output | 5 | Green field of the looked-up entry |
| pix_blue | output | 5 | Blue field of the looked-up entry |
| pix_hsync | output | 1 | Sync bit of the looked-up entry |
| fifo_empty | output | 1 | Read and write counters equal |
| fifo_full | output | 1 | 127 words held |
| fifo_ovf | output | 1 | Sticky flag: a push was dropped |

## Verification
The bench builds the block at its default size of 128 words of 32 bits with 8-bit pixel indices. At this size, a run of 127 pushes is short enough to reach the full state, the dropped push and a pop against a full queue within one test. The same size lets every one of the 256 pixel indices be looked up at each of the four depths. This covers the masking and the half selection for every word of the palette.

// File: rtl/pf_pkg.sv
package pf_pkg;

    typedef enum logic [1:0] {
        MODE_RAM  = 2'd0,
        MODE_FIFO = 2'd1,
        MODE_CLUT = 2'd2
    } mode_e;

    typedef struct packed {
        logic       sync;
        logic [4:0] red;
        logic [4:0] green;
        logic [4:0] blue;
    } colour_t;

endpackage

// File: rtl/pf_mem.sv
module pf_mem #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             a_re,
    input  logic [AW-1:0]    a_addr,
    output logic [WIDTH-1:0] a_rdata,
    input  logic             b_re,
    input  logic [AW-1:0]    b_addr,
    output logic [WIDTH-1:0] b_rdata
);

    logic [WIDTH-1:0] store [DEPTH];

    // single write path: arbitration happens upstream
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // registered reads, old data on a same-address write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (a_re) a_rdata <= store[a_addr];
            if (b_re) b_rdata <= store[b_addr];
        end
    end

endmodule

// File: rtl/pf_clut_index.sv
module pf_clut_index #(
    parameter int PIX_W = 8,
    parameter int AW    = 7
) (
    input  logic [1:0]       bpp,
    input  logic [PIX_W-1:0] idx,
    output logic [AW-1:0]    word_addr,
    output logic             half
);

    logic [PIX_W-1:0] mask;
    logic [PIX_W-1:0] masked;

    always_comb begin
        case (bpp)
            2'd0:    mask = PIX_W'(1);
            2'd1:    mask = PIX_W'(3);
            2'd2:    mask = PIX_W'(15);
            default: mask = '1;
        endcase
        masked    = idx & mask;
        half      = masked[0];
        word_addr = AW'(masked >> 1);
    end

endmodule

// File: rtl/fifo_clut_ram.sv
module fifo_clut_ram
    import pf_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int WIDTH = 32,
    parameter int PIX_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [1:0]               cfg_mode,
    input  logic                     cfg_dir,
    input  logic [1:0]               cfg_bpp,
    input  logic                     c_en,
    input  logic                     c_we,
    input  logic [$clog2(DEPTH)-1:0] c_addr,
    input  logic [WIDTH-1:0]         c_wdata,
    output logic [WIDTH-1:0]         c_rdata,
    input  logic                     io_en,
    input  logic                     io_we,
    input  logic [$clog2(DEPTH)-1:0] io_addr,
    input  logic [WIDTH-1:0]         io_wdata,
    output logic [WIDTH-1:0]         io_rdata,
    input  logic [PIX_W-1:0]         pix_idx,
    output logic [4:0]               pix_red,
    output logic [4:0]               pix_green,
    output logic [4:0]               pix_blue,
    output logic                     pix_hsync,
    output logic                     fifo_empty,
    output logic                     fifo_full,
    output logic                     fifo_ovf
);

    localparam int AW   = $clog2(DEPTH);
    localparam int HALF = WIDTH / 2;

    typedef struct packed {
        mode_e         mode;
        logic          dir;
        logic [1:0]    bpp;
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic          ovf;
        logic          half;
    } st_t;

    st_t st_q, st_d;

    logic          is_fifo, is_clut, empty, full;
    logic          w_en, w_we, r_en, r_we;
    logic [WIDTH-1:0] w_data;
    logic          push_req, pop_req, push_ok, pop_ok;
    logic          mw_en;
    logic [AW-1:0] mw_addr;
    logic [WIDTH-1:0] mw_data;
    logic          a_re, b_re;
    logic [AW-1:0] a_addr, b_addr;
    logic [AW-1:0] clut_addr;
    logic          clut_half;
    logic          lookup;
    logic [HALF-1:0] entry;
    colour_t       col;

    pf_clut_index #(.PIX_W(PIX_W), .AW(AW)) u_idx (
        .bpp       (st_q.bpp),
        .idx       (pix_idx),
        .word_addr (clut_addr),
        .half      (clut_half)
    );

    always_comb begin
        st_d    = st_q;
        is_fifo = (st_q.mode == MODE_FIFO);
        is_clut = (st_q.mode == MODE_CLUT);
        empty   = (st_q.wp == st_q.rp);
        full    = (AW'(st_q.wp + 1'b1) == st_q.rp);

        // role selection for the queue
        w_en   = st_q.dir ? io_en    : c_en;
        w_we   = st_q.dir ? io_we    : c_we;
        w_data = st_q.dir ? io_wdata : c_wdata;
        r_en   = st_q.dir ? c_en     : io_en;
        r_we   = st_q.dir ? c_we     : io_we;

        push_req = is_fifo && w_en && w_we;
        pop_req  = is_fifo && r_en && !r_we;
        push_ok  = push_req && !full;
        pop_ok   = pop_req && !empty;
        lookup   = is_clut && io_en && !io_we;

        // write arbitration
        mw_en   = 1'b0;
        mw_addr = c_addr;
        mw_data = c_wdata;
        if (is_fifo) begin
            mw_en   = push_ok;
            mw_addr = st_q.wp;
            mw_data = w_data;
        end else if (c_en && c_we) begin
            mw_en = 1'b1;
        end else if (!is_clut && io_en && io_we) begin
            mw_en   = 1'b1;
            mw_addr = io_addr;
            mw_data = io_wdata;
        end

        // core-side read
        a_addr = c_addr;
        a_re   = c_en && !c_we;
        if (is_fifo && st_q.dir) begin
            a_addr = st_q.rp;
            a_re   = pop_ok;
        end

        // io-side read
        b_addr = io_addr;
        b_re   = io_en && !io_we;
        if (is_fifo && !st_q.dir) begin
            b_addr = st_q.rp;
            b_re   = pop_ok;
        end else if (is_clut) begin
            b_addr = clut_addr;
        end

        // next state
        if (cfg_wr) begin
            case (cfg_mode)
                2'd1:    st_d.mode = MODE_FIFO;
                2'd2:    st_d.mode = MODE_CLUT;
                default: st_d.mode = MODE_RAM;
            endcase
            st_d.dir = cfg_dir;
            st_d.bpp = cfg_bpp;
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.ovf = 1'b0;
        end else begin
            if (push_ok) st_d.wp = AW'(st_q.wp + 1'b1);
            if (pop_ok)  st_d.rp = AW'(st_q.rp + 1'b1);
            if (push_req && full) st_d.ovf = 1'b1;
        end
        if (lookup) st_d.half = clut_half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_RAM, dir: 1'b0, bpp: 2'd0, wp: '0, rp: '0,
                      ovf: 1'b0, half: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    pf_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mw_en),
        .waddr   (mw_addr),
        .wdata   (mw_data),
        .a_re    (a_re),
        .a_addr  (a_addr),
        .a_rdata (c_rdata),
        .b_re    (b_re),
        .b_addr  (b_addr),
        .b_rdata (io_rdata)
    );

    always_comb begin
        entry     = st_q.half ? io_rdata[WIDTH-1:HALF] : io_rdata[HALF-1:0];
        col       = colour_t'(entry[15:0]);
        pix_hsync = col.sync;
        pix_red   = col.red;
        pix_green = col.green;
        pix_blue  = col.blue;
    end

    assign fifo_empty = empty;
    assign fifo_full  = full;
    assign fifo_ovf   = st_q.ovf;

endmodule

// File: rtl/fifo_clut_ram_chk.sv
module fifo_clut_ram_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [1:0]       cfg_mode,
    input logic             cfg_dir,
    input logic             c_en,
    input logic             c_we,
    input logic             io_en,
    input logic             io_we,
    input logic [WIDTH-1:0] c_rdata,
    input logic [WIDTH-1:0] io_rdata,
    input logic             fifo_empty,
    input logic             fifo_full,
    input logic             fifo_ovf
);

    logic fifo_q, dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_q <= 1'b0;
            dir_q  <= 1'b0;
        end else if (cfg_wr) begin
            fifo_q <= (cfg_mode == 2'd1);
            dir_q  <= cfg_dir;
        end
    end

    logic push_w, pop_w;
    assign push_w = fifo_q && (dir_q ? (io_en && io_we) : (c_en && c_we));
    assign pop_w  = fifo_q && (dir_q ? (c_en && !c_we) : (io_en && !io_we));

    AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full)); // R5

    AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (fifo_empty && !fifo_ovf)); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ovf && !cfg_wr) |=> fifo_ovf); // R6

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && push_w && !pop_w && !cfg_wr) |=> (fifo_full && fifo_ovf)); // R6

    AST_POP_EMPTY_IO: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_q && !dir_q && fifo_empty && pop_w && !cfg_wr) |=> $stable(io_rdata)); // R7

    AST_POP_EMPTY_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_q && dir_q && fifo_empty && pop_w && !cfg_wr) |=> $stable(c_rdata)); // R7

endmodule

bind fifo_clut_ram fifo_clut_ram_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/fifo_clut_ram_tb.sv
module fifo_clut_ram_tb;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cfg_wr = 0, cfg_dir = 0;
    logic [1:0]  cfg_mode = 0, cfg_bpp = 0;
    logic        c_en = 0, c_we = 0, io_en = 0, io_we = 0;
    logic [6:0]  c_addr = 0, io_addr = 0;
    logic [31:0] c_wdata = 0, io_wdata = 0;
    logic [7:0]  pix_idx = 0;
    logic [31:0] c_rdata, io_rdata;
    logic [4:0]  pix_red, pix_green, pix_blue;
    logic        pix_hsync, fifo_empty, fifo_full, fifo_ovf;

    fifo_clut_ram u_dut (.*);

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // behavioural reference
    logic [31:0] mm [128];
    logic [31:0] q [$];
    int          m_mode = 0, m_dir = 0, m_bpp = 0, m_wp = 0;
    logic        m_ovf = 0, m_half = 0;
    logic [31:0] m_c = 0, m_io = 0;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [15:0] col;
        col = m_half ? m_io[31:16] : m_io[15:0];
        chk("c_rdata", c_rdata, m_c);
        chk("io_rdata", io_rdata, m_io);
        chk("colour", {16'h0, pix_hsync, pix_red, pix_green, pix_blue}, {16'h0, col});
        chk("empty", {31'h0, fifo_empty}, {31'h0, q.size() == 0});
        chk("full", {31'h0, fifo_full}, {31'h0, q.size() == 127});
        chk("ovf", {31'h0, fifo_ovf}, {31'h0, m_ovf});
    endtask

    task automatic model_step();
        logic [31:0] nc, nio, rv;
        logic        nh, wen, wwe, ren, rwe;
        logic [31:0] wd;
        int          oldsz, bits, midx;
        nc = m_c; nio = m_io; nh = m_half;
        if (cfg_wr) begin
            m_mode = (cfg_mode == 3) ? 0 : int'(cfg_mode);
            m_dir  = int'(cfg_dir);
            m_bpp  = int'(cfg_bpp);
            q.delete();
            m_ovf = 0;
            m_wp  = 0;
            return;
        end
        if (m_mode == 1) begin
            wen = m_dir ? io_en : c_en;  wwe = m_dir ? io_we : c_we;
            ren = m_dir ? c_en : io_en;  rwe = m_dir ? c_we : io_we;
            wd  = m_dir ? io_wdata : c_wdata;
            oldsz = q.size();
            if (ren && !rwe && oldsz > 0) begin
                rv = q.pop_front();
                if (m_dir == 0) nio = rv; else nc = rv;
            end
            if (wen && wwe) begin
                if (oldsz == 127) m_ovf = 1;
                else begin
                    q.push_back(wd);
                    mm[m_wp] = wd;
                    m_wp = (m_wp + 1) % 128;
                end
            end
        end else if (m_mode == 2) begin
            if (c_en && !c_we) nc = mm[c_addr];
            if (io_en && !io_we) begin
                bits = 1 << m_bpp;
                midx = int'(pix_idx) & ((1 << bits) - 1);
                nio  = mm[midx >> 1];
                nh   = midx[0];
            end
            if (c_en && c_we) mm[c_addr] = c_wdata;
        end else begin
            if (c_en && !c_we) nc = mm[c_addr];
            if (io_en && !io_we) nio = mm[io_addr];
            if (c_en && c_we) mm[c_addr] = c_wdata;
            else if (io_en && io_we) mm[io_addr] = io_wdata;
        end
        m_c = nc; m_io = nio; m_half = nh;
    endtask

    task automatic idle();
        cfg_wr = 0; c_en = 0; c_we = 0; io_en = 0; io_we = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        idle();
    endtask

    task automatic cfg(int mode, int dir, int bpp);
        cfg_wr = 1; cfg_mode = 2'(mode); cfg_dir = 1'(dir); cfg_bpp = 2'(bpp);
        tick();
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        tag = "R1";
        compare_all();
        @(negedge clk);

        // R2: fill and read back in RAM mode
        tag = "R2";
        for (int i = 0; i < 128; i++) begin
            c_en = 1; c_we = 1; c_addr = 7'(i);
            c_wdata = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101);
            if (i > 0) begin io_en = 1; io_addr = 7'(i - 1); end
            tick();
        end
        for (int i = 0; i < 128; i++) begin
            c_en = 1; c_addr = 7'(i); io_en = 1; io_addr = 7'(127 - i);
            tick();
        end
        c_en = 1; c_we = 1; c_addr = 5; c_wdata = 32'h1234_5678;
        io_en = 1; io_addr = 5;
        tick();
        io_en = 1; io_addr = 5; tick();
        io_en = 1; io_we = 1; io_addr = 30; io_wdata = 32'hCAFE_0030; tick();
        c_en = 1; c_addr = 30; tick();

        // R3: write collision
        tag = "R3";
        c_en = 1; c_we = 1; c_addr = 20; c_wdata = 32'h0000_C0DE;
        io_en = 1; io_we = 1; io_addr = 20; io_wdata = 32'h0000_BAD0;
        tick();
        c_en = 1; c_addr = 20; io_en = 1; io_addr = 20; tick();

        // R8: reader port write locked in FIFO mode
        tag = "R8";
        cfg(1, 0, 0);
        io_en = 1; io_we = 1; io_addr = 100; io_wdata = 32'hDEAD_BEEF; tick();
        cfg(0, 0, 0);
        c_en = 1; c_addr = 100; tick();

        // R4: ordered queue, core writes, io reads
        tag = "R4";
        cfg(1, 0, 0);
        for (int i = 0; i < 6; i++) begin
            c_en = 1; c_we = 1; c_wdata = 32'h4000_0000 + 32'(i); tick();
        end
        for (int i = 0; i < 4; i++) begin
            io_en = 1; c_en = 1; c_we = 1; c_wdata = 32'h4100_0000 + 32'(i); tick();
        end
        for (int i = 0; i < 6; i++) begin io_en = 1; tick(); end

        // R7: pop on empty
        tag = "R7";
        io_en = 1; tick();
        io_en = 1; tick();

        // R5 / R6: fill to full, then overflow
        tag = "R5";
        for (int i = 0; i < 127; i++) begin
            c_en = 1; c_we = 1; c_wdata = 32'h5000_0000 + 32'(i); tick();
        end
        tag = "R6";
        c_en = 1; c_we = 1; c_wdata = 32'h6666_6666; tick();
        repeat (3) tick();
        c_en = 1; c_we = 1; c_wdata = 32'h6777_7777; io_en = 1; tick();
        tag = "R4";
        for (int i = 0; i < 127; i++) begin io_en = 1; tick(); end

        // R9: configuration write clears
        tag = "R9";
        c_en = 1; c_we = 1; c_wdata = 32'h9; tick();
        cfg(1, 1, 0);

        // R10: io writes, core reads
        tag = "R10";
        for (int i = 0; i < 4; i++) begin
            io_en = 1; io_we = 1; io_wdata = 32'hA000_0000 + 32'(i); tick();
        end
        c_en = 1; c_we = 1; c_addr = 3; c_wdata = 32'h1111; tick();
        for (int i = 0; i < 5; i++) begin c_en = 1; tick(); end

        // R12: palette entries with known fields
        tag = "R12";
        cfg(2, 0, 3);
        c_en = 1; c_we = 1; c_addr = 3; c_wdata = {1'b0, 5'h03, 5'h1F, 5'h00, 16'hFC0A}; tick();
        io_en = 1; pix_idx = 8'd6; tick();
        io_en = 1; pix_idx = 8'd7; tick();

        // R13: io writes ignored in palette mode
        tag = "R13";
        io_en = 1; io_we = 1; io_addr = 3; io_wdata = 32'h0; tick();
        io_en = 1; pix_idx = 8'd7; tick();
        c_en = 1; c_addr = 3; tick();

        // R11: all indices at all depths
        tag = "R11";
        for (int b = 0; b < 4; b++) begin
            cfg(2, 0, b);
            for (int k = 0; k < 256; k++) begin
                io_en = 1; pix_idx = 8'(k); tick();
            end
        end

        finish_up();
    end

endmodule